// File: doc/BRIEF.md
# Keyed Power-Control Register Block

This block holds the command and mode settings of a low-power supply controller behind a simple register port. Every write to the command word or the mode word carries an 8-bit key in its top byte; the write changes nothing unless that byte equals the key the block was built with. Accepted commands can stop the voltage regulator, which also raises a core reset request, and can move the slow clock from the internal RC oscillator over to the crystal. The move to the crystal is one-way and lasts until the block itself is reset.

The mode word selects crystal bypass, lets a brownout event raise core reset, turns the brownout detector off and flags the regulator as in use. The raw brownout comparator output is brought in through a two-flop synchronizer and checked for rising edges. Each edge sets a sticky status flag that a status read clears. Reads return their data one cycle after the read strobe.

Top module: `pwr_ctl_regs`

## Requirements
- R1: After reset every control output is 0, the slow clock reports the RC source, and status bits 3 and 7 read 0.
- R2: A write to the command word (address 0) or the mode word (address 1) whose bits 31:24 differ from the key (default 8'hA5) changes no output and no readable field.
- R3: A keyed command write with bit 2 set raises reg_stop_req and core_rst_req on the next cycle, and both stay high until reset; a keyed command write with bit 2 clear leaves them low.
- R4: A keyed command write with bit 3 set drives clk_sel_xtal to 1 from the next cycle, and no later write returns it to 0 before reset.
- R5: Mode bit 20 sets xtal_bypass and forces clk_sel_xtal to 1; when bit 20 is cleared, clk_sel_xtal follows the crystal-select command state again.
- R6: Mode bit 12 drives bod_rst_en, bit 13 drives bod_disable and bit 14 drives reg_in_use; a read of address 1 returns these bits and bit 20 at the same positions with every other bit 0.
- R7: Status (address 2) bit 7 reads 1 exactly when clk_sel_xtal is 1; reads of address 0 return 0.
- R8: A rising edge of bod_in, with the detector enabled, sets status bit 3 on the third clock edge after the input changes; a status read clears it.
- R9: If a status read and the setting of status bit 3 fall on the same edge, the read returns the old value (0) and the bit stays set.
- R10: With bod_rst_en set and the detector enabled, a brownout rising edge raises core_rst_req for exactly one cycle, on the same edge that sets status bit 3; with bod_rst_en clear it raises no reset, and with bod_disable set it raises neither a reset nor the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 2 | Word address: 0 command, 1 mode, 2 status |
| bus_wdata | input | 32 | Write data, key in bits 31:24 |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after bus_rd |
| bod_in | input | 1 | Asynchronous brownout comparator output |
| reg_stop_req | output | 1 | Request to stop the voltage regulator |
| core_rst_req | output | 1 | Core reset request |
| clk_sel_xtal | output | 1 | Slow clock source: 0 RC, 1 crystal |
| xtal_bypass | output | 1 | Crystal oscillator in bypass mode |
| bod_rst_en | output | 1 | Brownout may raise core reset |
| bod_disable | output | 1 | Brownout detector switched off |
| reg_in_use | output | 1 | Voltage regulator marked as in use |

## Verification
The hardest case to reach is a status read that lands on the same edge that sets the brownout flag, because the setting edge comes out of a synchronizer and an edge detector three registers after the pin. The bench changes bod_in just after a known edge, counts two further edges and raises the read strobe for the third. It then checks that the returned word still shows bit 3 clear and that a second read finds it set. The key check is swept over all 256 key values on both writable words, and all sixteen mode field combinations are applied and read back.

// File: rtl/pwr_ctl_pkg.sv
// Shared constants and types of the keyed power-control register block.
// Assumes a 32-bit data word with the key in the top byte.
package pwr_ctl_pkg;
    localparam int ADDR_W  = 2;
    localparam int DATA_W  = 32;
    localparam int KEY_W   = 8;
    localparam int KEY_LSB = DATA_W - KEY_W;

    localparam logic [ADDR_W-1:0] ADDR_CMD  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

    localparam int CMD_STOP_BIT    = 2;
    localparam int CMD_XTAL_BIT    = 3;
    localparam int MODE_BODRST_BIT = 12;
    localparam int MODE_BODDIS_BIT = 13;
    localparam int MODE_REGUSE_BIT = 14;
    localparam int MODE_BYPASS_BIT = 20;
    localparam int STAT_BOD_BIT    = 3;
    localparam int STAT_CLK_BIT    = 7;

    typedef struct packed {
        logic bypass;
        logic reg_use;
        logic bod_dis;
        logic bod_rst_en;
    } mode_t;
endpackage

// File: rtl/pwr_ctl_sync.sv
// Multi-stage synchronizer for a single asynchronous level.
// Assumes STAGES >= 1; output resets to 0.
module pwr_ctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_async;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pwr_ctl_cfg.sv
// Command and mode storage. Accepts a write only when its top byte equals
// KEY. Regulator stop and crystal select are sticky until reset.
module pwr_ctl_cfg
    import pwr_ctl_pkg::*;
#(
    parameter logic [KEY_W-1:0] KEY = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output mode_t             mode_o,
    output logic              stop_o,
    output logic              xtal_o
);
    logic  key_ok;
    logic  cmd_hit;
    logic  mode_hit;
    logic  unused_wdata;
    mode_t mode_q;
    logic  stop_q;
    logic  xtal_q;

    // Decode the key and the target word of the current write.
    assign key_ok       = (wr_data[DATA_W-1:KEY_LSB] == KEY);
    assign cmd_hit      = wr_en && (wr_addr == ADDR_CMD)  && key_ok;
    assign mode_hit     = wr_en && (wr_addr == ADDR_MODE) && key_ok;
    assign unused_wdata = ^wr_data;

    // Latch accepted commands and mode fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            stop_q <= 1'b0;
            xtal_q <= 1'b0;
        end else begin
            if (cmd_hit && wr_data[CMD_STOP_BIT]) stop_q <= 1'b1;
            if (cmd_hit && wr_data[CMD_XTAL_BIT]) xtal_q <= 1'b1;
            if (mode_hit) begin
                mode_q.bypass     <= wr_data[MODE_BYPASS_BIT];
                mode_q.reg_use    <= wr_data[MODE_REGUSE_BIT];
                mode_q.bod_dis    <= wr_data[MODE_BODDIS_BIT];
                mode_q.bod_rst_en <= wr_data[MODE_BODRST_BIT];
            end
        end
    end

    assign mode_o = mode_q;
    assign stop_o = stop_q;
    assign xtal_o = xtal_q;

    assert_badkey_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == ADDR_MODE) && !key_ok) |=> $stable(mode_q));
    assert_badkey_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !key_ok) |=> ($stable(stop_q) && $stable(xtal_q)));
    assert_stop_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q |=> stop_q);
    assert_xtal_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xtal_q |=> xtal_q);
endmodule

// File: rtl/pwr_ctl_stat.sv
// Brownout edge detection, sticky status flag and registered read mux.
// Assumes bod_sync is already synchronous to clk. A set of the flag wins
// over a clearing read on the same edge.
module pwr_ctl_stat
    import pwr_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bod_sync,
    input  mode_t             mode_i,
    input  logic              clk_xtal,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rdata,
    output logic              bod_rst_pulse
);
    logic              bod_prev_q;
    logic              bod_edge;
    logic              bod_seen_q;
    logic              stat_rd;
    logic              pulse_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] stat_word;
    logic [DATA_W-1:0] mode_word;

    // Rising edge of the synchronized brownout, ignored when disabled.
    assign bod_edge = bod_sync && !bod_prev_q && !mode_i.bod_dis;
    assign stat_rd  = rd_en && (rd_addr == ADDR_STAT);

    // Assemble the status and mode read words.
    always_comb begin
        stat_word               = '0;
        stat_word[STAT_BOD_BIT] = bod_seen_q;
        stat_word[STAT_CLK_BIT] = clk_xtal;
        mode_word                  = '0;
        mode_word[MODE_BODRST_BIT] = mode_i.bod_rst_en;
        mode_word[MODE_BODDIS_BIT] = mode_i.bod_dis;
        mode_word[MODE_REGUSE_BIT] = mode_i.reg_use;
        mode_word[MODE_BYPASS_BIT] = mode_i.bypass;
    end

    // Track the brownout level, the sticky flag and the reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bod_prev_q <= 1'b0;
            bod_seen_q <= 1'b0;
            pulse_q    <= 1'b0;
        end else begin
            bod_prev_q <= bod_sync;
            pulse_q    <= bod_edge && mode_i.bod_rst_en;
            if (bod_edge)     bod_seen_q <= 1'b1;
            else if (stat_rd) bod_seen_q <= 1'b0;
        end
    end

    // Register the read data selected by the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            case (rd_addr)
                ADDR_MODE: rdata_q <= mode_word;
                ADDR_STAT: rdata_q <= stat_word;
                default:   rdata_q <= '0;
            endcase
        end
    end

    assign rdata         = rdata_q;
    assign bod_rst_pulse = pulse_q;

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bod_edge |=> bod_seen_q);
    assert_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bod_seen_q) |-> $past(bod_edge));
    assert_dis_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i.bod_dis |=> !pulse_q);
    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);
endmodule

// File: rtl/pwr_ctl_regs.sv
// Top of the keyed power-control register block: register port, keyed
// command and mode storage, brownout synchronizer and status.
// Assumes one-cycle strobes on bus_wr and bus_rd; reset is synchronous.
module pwr_ctl_regs
    import pwr_ctl_pkg::*;
#(
    parameter logic [KEY_W-1:0] KEY         = 8'hA5,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              bod_in,
    output logic              reg_stop_req,
    output logic              core_rst_req,
    output logic              clk_sel_xtal,
    output logic              xtal_bypass,
    output logic              bod_rst_en,
    output logic              bod_disable,
    output logic              reg_in_use
);
    mode_t mode;
    logic  stop;
    logic  xtal_cmd;
    logic  bod_s;
    logic  bod_pulse;

    pwr_ctl_cfg #(.KEY(KEY)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .mode_o  (mode),
        .stop_o  (stop),
        .xtal_o  (xtal_cmd)
    );

    pwr_ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (bod_in),
        .q_sync  (bod_s)
    );

    pwr_ctl_stat u_stat (
        .clk           (clk),
        .rst_n         (rst_n),
        .bod_sync      (bod_s),
        .mode_i        (mode),
        .clk_xtal      (clk_sel_xtal),
        .rd_en         (bus_rd),
        .rd_addr       (bus_addr),
        .rdata         (bus_rdata),
        .bod_rst_pulse (bod_pulse)
    );

    // Drive the control outputs from stored state.
    assign clk_sel_xtal = xtal_cmd | mode.bypass;
    assign xtal_bypass  = mode.bypass;
    assign reg_stop_req = stop;
    assign core_rst_req = stop | bod_pulse;
    assign bod_rst_en   = mode.bod_rst_en;
    assign bod_disable  = mode.bod_dis;
    assign reg_in_use   = mode.reg_use;

    assert_rc_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!clk_sel_xtal && !reg_stop_req && !core_rst_req));
    assert_stop_means_rst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_stop_req) |-> $past(bus_wr && bus_addr == ADDR_CMD));
endmodule

// File: tb/tb_pwr_ctl_regs.sv
module tb_pwr_ctl_regs;
    localparam int       CLK_PERIOD = 10;
    localparam logic [7:0] KEY      = 8'hA5;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [1:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        bod_in = 0;
    logic        reg_stop_req, core_rst_req, clk_sel_xtal, xtal_bypass;
    logic        bod_rst_en, bod_disable, reg_in_use;
    int          total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_ctl_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bod_in(bod_in), .reg_stop_req(reg_stop_req), .core_rst_req(core_rst_req),
        .clk_sel_xtal(clk_sel_xtal), .xtal_bypass(xtal_bypass),
        .bod_rst_en(bod_rst_en), .bod_disable(bod_disable), .reg_in_use(reg_in_use)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] outs();
        return {25'd0, reg_stop_req, core_rst_req, clk_sel_xtal, xtal_bypass,
                bod_rst_en, bod_disable, reg_in_use};
    endfunction

    // Expected output vector from mode bits {bypass,reguse,boddis,bodrst}.
    function automatic logic [31:0] exp_outs(input logic stop, input logic xsel,
                                             input logic [3:0] m);
        return {25'd0, stop, stop, xsel | m[3], m[3], m[0], m[1], m[2]};
    endfunction

    function automatic logic [31:0] mode_data(input logic [7:0] k, input logic [3:0] m);
        logic [31:0] d = 32'd0;
        d[31:24] = k; d[12] = m[0]; d[13] = m[1]; d[14] = m[2]; d[20] = m[3];
        return d;
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        @(negedge clk); bus_rd = 0; d = bus_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        do_reset();
        // R1 reset state
        @(negedge clk);
        chk("R1 outputs", outs(), 32'd0);
        rd(2'd2, r); chk("R1 status", r, 32'd0);

        // R2 wrong keys on mode word with all fields set
        for (int k = 0; k < 256; k++) begin
            if (k[7:0] != KEY) begin
                wr(2'd1, mode_data(k[7:0], 4'hF));
                chk("R2 mode bad key", outs(), 32'd0);
            end
        end
        rd(2'd1, r); chk("R2 mode readback", r, 32'd0);

        // R6 R5 all mode combinations with the right key
        for (int m = 0; m < 16; m++) begin
            wr(2'd1, mode_data(KEY, m[3:0]));
            chk("R6 R5 outputs", outs(), exp_outs(1'b0, 1'b0, m[3:0]));
            rd(2'd1, r); chk("R6 readback", r, mode_data(8'd0, m[3:0]));
            rd(2'd2, r); chk("R7 status clk", r, {24'd0, m[3], 7'd0});
        end
        wr(2'd1, mode_data(KEY, 4'h0));
        chk("R5 back to RC", {31'd0, clk_sel_xtal}, 32'd0);

        // R8 R10 brownout with reset enabled
        wr(2'd1, mode_data(KEY, 4'b0001));
        @(negedge clk); bod_in = 1;
        @(negedge clk); chk("R10 no early rst", {31'd0, core_rst_req}, 32'd0);
        @(negedge clk); chk("R10 no early rst", {31'd0, core_rst_req}, 32'd0);
        @(negedge clk); chk("R10 rst pulse", {31'd0, core_rst_req}, 32'd1);
        @(negedge clk); chk("R10 pulse ends", {31'd0, core_rst_req}, 32'd0);
        rd(2'd2, r); chk("R8 status set", r, 32'h8);
        rd(2'd2, r); chk("R8 read clears", r, 32'h0);
        @(negedge clk); bod_in = 0;
        repeat (4) @(negedge clk);

        // R10 detector disabled: no status, no reset
        wr(2'd1, mode_data(KEY, 4'b0011));
        @(negedge clk); bod_in = 1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); chk("R10 disabled no rst", {31'd0, core_rst_req}, 32'd0);
        end
        rd(2'd2, r); chk("R10 disabled no status", r, 32'h0);
        @(negedge clk); bod_in = 0;
        repeat (4) @(negedge clk);

        // R10 reset not enabled: status only
        wr(2'd1, mode_data(KEY, 4'b0000));
        @(negedge clk); bod_in = 1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); chk("R10 not enabled no rst", {31'd0, core_rst_req}, 32'd0);
        end
        rd(2'd2, r); chk("R8 status without rst", r, 32'h8);
        @(negedge clk); bod_in = 0;
        repeat (4) @(negedge clk);

        // R9 read on the setting edge
        @(negedge clk); bod_in = 1;
        @(negedge clk);
        @(negedge clk); bus_rd = 1; bus_addr = 2'd2;
        @(negedge clk); bus_rd = 0;
        chk("R9 read returns old", bus_rdata, 32'h0);
        rd(2'd2, r); chk("R9 set wins", r, 32'h8);
        @(negedge clk); bod_in = 0;
        repeat (4) @(negedge clk);

        // R2 R4 wrong keys on crystal select, then right key
        for (int k = 0; k < 256; k++) begin
            if (k[7:0] != KEY) begin
                wr(2'd0, {k[7:0], 24'h00000C});
                chk("R2 cmd bad key", outs(), 32'd0);
            end
        end
        wr(2'd0, {KEY, 24'h000000});
        chk("R3 R4 bits clear no effect", outs(), 32'd0);
        wr(2'd0, {KEY, 24'h000008});
        chk("R4 crystal selected", outs(), exp_outs(1'b0, 1'b1, 4'h0));
        wr(2'd1, mode_data(KEY, 4'b1000));
        wr(2'd1, mode_data(KEY, 4'b0000));
        wr(2'd0, {KEY, 24'h000000});
        chk("R4 stays crystal", outs(), exp_outs(1'b0, 1'b1, 4'h0));
        rd(2'd2, r); chk("R7 status crystal", r, 32'h80);
        rd(2'd0, r); chk("R7 cmd reads zero", r, 32'h0);

        // R3 regulator stop
        wr(2'd0, {KEY, 24'h000004});
        chk("R3 stop", outs(), exp_outs(1'b1, 1'b1, 4'h0));
        repeat (3) @(negedge clk);
        wr(2'd1, mode_data(KEY, 4'h0));
        chk("R3 stop sticky", outs(), exp_outs(1'b1, 1'b1, 4'h0));

        // R1 reset restores everything
        do_reset();
        @(negedge clk);
        chk("R1 outputs after reset", outs(), 32'd0);
        rd(2'd2, r); chk("R1 status after reset", r, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule